// File: doc/BRIEF.md
# Asymmetric Center-Aligned PWM Generator

This block generates one pulse-width-modulated reference signal. Its period counter can run in two ways. In edge-aligned mode it counts up and wraps. In center-aligned mode it climbs from zero to a reload value and then descends back to zero. In center-aligned mode the output is compared against one threshold on the way up and, in asymmetric mode, against a second threshold on the way down. Moving the second threshold moves only the trailing edge of the pulse, which gives a programmable phase shift between channels built from this block.

Reload, both thresholds and the counting mode are captured into shadow copies on the clock edge that takes the counter to zero, so an update written mid-period never disturbs the current period. A small two-state machine tracks the direction. State UP covers the ascending half and the zero cycle. State DOWN covers the reload cycle and the descent. The machine has three transitions:
- UP goes to DOWN when the next count equals a non-zero reload in a center mode.
- DOWN goes to UP when the next count is zero.
- In edge-aligned mode every transition leads to UP.

Top module: `asym_cpwm`

## Requirements
- R1: While reset is asserted, the counter reads 0, the direction flag reads 0 (up) and the output reference is low.
- R2: Mode code 2'b00 selects edge-aligned counting. The counter steps by one per enabled clock up to the reload value, returns to 0 on the next clock, and the direction flag stays 0.
- R3: Mode codes 2'b01 and 2'b1x select center-aligned counting. The counter runs 0,1,…,reload,reload-1,…,1,0, so the period is 2×reload clocks. Each extreme value is held for exactly one clock.
- R4: The direction flag is 1 (down) from the cycle the counter equals the reload value through the last cycle before it reaches 0. It is 0 on the zero cycle and while ascending.
- R5: While the direction flag is 0, the output reference is high exactly when the counter is below the up-count threshold.
- R6: With mode code 2'b1x, the output reference is high exactly when the counter is below the down-count threshold while the direction flag is 1.
- R7: With mode codes 2'b00 and 2'b01, the down-count threshold has no effect on the output. The up-count threshold is used in both directions.
- R8: Reload, thresholds and mode take effect only from the clock edge that brings the counter to 0. A change made mid-period leaves the running period unchanged.
- R9: With an active reload value of 0, the counter stays at 0 with the direction flag 0. New inputs are captured on every enabled clock.
- R10: While enable is low, the counter, direction flag and output reference hold their values.
- R11: With reload 8 and up-count threshold 3, a down-count threshold of 5 makes the output rise 2 clocks earlier in the descent than symmetric mode does. Swapping the thresholds to 5 and 3 makes it rise 2 clocks later than a symmetric threshold of 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Count enable |
| mode_i | input | 2 | 00 edge-aligned, 01 center symmetric, 1x center asymmetric |
| reload_i | input | CW | Reload (peak) value |
| cmp_up_i | input | CW | Threshold used while ascending |
| cmp_dn_i | input | CW | Threshold used while descending in asymmetric mode |
| cnt_o | output | CW | Current counter value |
| dir_o | output | 1 | Direction flag, 1 = down |
| oref_o | output | 1 | Output reference |

## Verification
The counter and the direction flag change one clock edge after the enabled cycle that decides them. The output reference is a compare of registered state, so it is valid in that same cycle. A new reload, threshold or mode is first visible in the cycle after the counter enters zero. The bench keeps a per-cycle arithmetic model that is advanced on the rising edge. It compares every output on the falling edge, when all registers have settled. The phase-shift check counts falling-edge samples from the reload cycle to the output's rise.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        MODE_EDGE     = 2'b00,
        MODE_SYM      = 2'b01,
        MODE_ASYM     = 2'b10,
        MODE_ASYM_ALT = 2'b11
    } cmode_e;
endpackage

// File: rtl/cpwm_shadow.sv
module cpwm_shadow
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] reload_i,
    input  logic [CW-1:0] cmp_up_i,
    input  logic [CW-1:0] cmp_dn_i,
    output cmode_e        mode_q,
    output logic [CW-1:0] reload_q,
    output logic [CW-1:0] cmp_up_q,
    output logic [CW-1:0] cmp_dn_q
);
    // Active-period copies, refreshed only on the edge entering zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= MODE_EDGE;
            reload_q <= '0;
            cmp_up_q <= '0;
            cmp_dn_q <= '0;
        end else if (load) begin
            mode_q   <= cmode_e'(mode_i);
            reload_q <= reload_i;
            cmp_up_q <= cmp_up_i;
            cmp_dn_q <= cmp_dn_i;
        end
    end
endmodule

// File: rtl/cpwm_seq.sv
module cpwm_seq
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          center,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt_q,
    output dir_e          state_q,
    output logic          at_zero_next
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_n;
    dir_e          state_n;

    // Next count and next direction state
    always_comb begin
        cnt_n = cnt_q;
        unique case (state_q)
            DIR_UP:   cnt_n = (cnt_q < reload) ? cnt_q + ONE : '0;
            DIR_DOWN: cnt_n = cnt_q - ONE;
        endcase
        if (!center)
            state_n = DIR_UP;
        else if (cnt_n == '0)
            state_n = DIR_UP;
        else if (cnt_n == reload)
            state_n = DIR_DOWN;
        else
            state_n = state_q;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIR_UP;
            cnt_q   <= '0;
        end else if (en) begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Outputs of the sequencer
    always_comb begin
        at_zero_next = en && (cnt_n == '0);
    end
endmodule

// File: rtl/cpwm_cmp.sv
module cpwm_cmp
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  cmode_e        mode,
    input  dir_e          dir,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] cmp_up,
    input  logic [CW-1:0] cmp_dn,
    output logic          oref
);
    logic [CW-1:0] thr;

    always_comb begin
        thr = cmp_up;
        unique case (mode)
            MODE_ASYM, MODE_ASYM_ALT: thr = (dir == DIR_DOWN) ? cmp_dn : cmp_up;
            MODE_EDGE, MODE_SYM:      thr = cmp_up;
        endcase
        oref = (cnt < thr);
    end
endmodule

// File: rtl/asym_cpwm.sv
module asym_cpwm
    import cpwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [1:0]    mode_i,
    input  logic [CW-1:0] reload_i,
    input  logic [CW-1:0] cmp_up_i,
    input  logic [CW-1:0] cmp_dn_i,
    output logic [CW-1:0] cnt_o,
    output logic          dir_o,
    output logic          oref_o
);
    cmode_e        mode_sh;
    logic [CW-1:0] rld_sh;
    logic [CW-1:0] cup_sh;
    logic [CW-1:0] cdn_sh;
    logic [CW-1:0] cnt;
    dir_e          state;
    logic          load;
    logic          center;

    assign center = (mode_sh != MODE_EDGE);

    cpwm_shadow #(.CW(CW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(load),
        .mode_i(mode_i), .reload_i(reload_i),
        .cmp_up_i(cmp_up_i), .cmp_dn_i(cmp_dn_i),
        .mode_q(mode_sh), .reload_q(rld_sh),
        .cmp_up_q(cup_sh), .cmp_dn_q(cdn_sh)
    );

    cpwm_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .center(center),
        .reload(rld_sh), .cnt_q(cnt), .state_q(state),
        .at_zero_next(load)
    );

    cpwm_cmp #(.CW(CW)) u_cmp (
        .mode(mode_sh), .dir(state), .cnt(cnt),
        .cmp_up(cup_sh), .cmp_dn(cdn_sh), .oref(oref_o)
    );

    assign cnt_o = cnt;
    assign dir_o = (state == DIR_DOWN);
endmodule

// File: rtl/cpwm_chk.sv
module cpwm_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [CW-1:0] cnt,
    input logic          dir,
    input logic          oref,
    input logic [CW-1:0] rld_sh
);
    localparam logic [CW-1:0] ONE = CW'(1);

    // R10
    en_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cnt) && $stable(dir) && $stable(oref)));

    // R3
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dir) |=> (cnt == $past(cnt) - ONE));

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dir) |=> ((cnt == $past(cnt) + ONE) || (cnt == '0)));

    // R4
    zero_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !dir);

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rld_sh) |-> (cnt == '0));
endmodule

bind asym_cpwm cpwm_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt_o),
    .dir(dir_o), .oref(oref_o), .rld_sh(rld_sh)
);

// File: tb/sim_asym_cpwm.sv
`timescale 1ns/1ps
module sim_asym_cpwm;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [CW-1:0] rld = '0, cup = '0, cdn = '0;
    logic [CW-1:0] cnt;
    logic          dir, oref;

    int checks = 0;
    int fails  = 0;
    string tag_ovr = "";

    // reference state
    int m_cnt = 0, m_dir = 0, m_rld = 0, m_uc = 0, m_dc = 0, m_mode = 0;

    always #2 clk = ~clk;

    asym_cpwm #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_i(mode),
        .reload_i(rld), .cmp_up_i(cup), .cmp_dn_i(cdn),
        .cnt_o(cnt), .dir_o(dir), .oref_o(oref)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_dir <= 0; m_rld <= 0; m_uc <= 0; m_dc <= 0; m_mode <= 0;
        end else if (en) begin
            int nc, nd;
            if (m_dir == 0) nc = (m_cnt < m_rld) ? m_cnt + 1 : 0;
            else            nc = m_cnt - 1;
            if (m_mode == 0)        nd = 0;
            else if (nc == 0)       nd = 0;
            else if (nc == m_rld)   nd = 1;
            else                    nd = m_dir;
            m_cnt <= nc;
            m_dir <= nd;
            if (nc == 0) begin
                m_rld <= int'(rld); m_uc <= int'(cup); m_dc <= int'(cdn); m_mode <= int'(mode);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // advance one clock, then compare every output at the falling edge
    task automatic step();
        string tc, tdir, to;
        int thr;
        @(negedge clk);
        tc   = (m_rld == 0) ? "R9" : ((m_mode == 0) ? "R2" : "R3");
        tdir = "R4";
        if (m_dir == 0)           to = "R5";
        else if (m_mode >= 2)     to = "R6";
        else                      to = "R7";
        if (tag_ovr != "") begin tc = tag_ovr; tdir = tag_ovr; to = tag_ovr; end
        thr = (m_mode >= 2 && m_dir == 1) ? m_dc : m_uc;
        chk(tc, int'(cnt), m_cnt);
        chk(tdir, int'(dir), m_dir);
        chk(to, int'(oref), (m_cnt < thr) ? 1 : 0);
    endtask

    task automatic measure_rise(output int k);
        int guard = 0;
        while (!(int'(cnt) == 8 && dir == 1'b1) && guard < 100) begin step(); guard++; end
        k = 0;
        while (oref == 1'b0 && k < 20) begin step(); k++; end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t_sym, t_asym;
        // R1 reset values
        repeat (3) @(negedge clk);
        chk("R1", int'(cnt), 0);
        chk("R1", int'(dir), 0);
        chk("R1", int'(oref), 0);
        rst_n = 1'b1;
        en    = 1'b1;

        // sweep: modes, reload 0..5, thresholds 0..reload+1
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r <= 5; r++) begin
                for (int u = 0; u <= r + 1; u++) begin
                    for (int d = 0; d <= r + 1; d++) begin
                        if (m == 3 && d != u) continue;
                        mode = 2'(m); rld = CW'(r); cup = CW'(u); cdn = CW'(d);
                        repeat (14) step();
                    end
                end
            end
        end

        // R10: freeze mid-period
        mode = 2'b10; rld = 16'd6; cup = 16'd2; cdn = 16'd4;
        repeat (20) step();
        while (!(int'(cnt) == 4 && dir == 1'b1)) step();
        en = 1'b0;
        tag_ovr = "R10";
        repeat (6) step();
        chk("R10", int'(cnt), 4);
        tag_ovr = "";
        en = 1'b1;
        repeat (10) step();

        // R8: mid-period change must not alter the running period
        mode = 2'b01; rld = 16'd6; cup = 16'd2;
        repeat (30) step();
        while (!(int'(cnt) == 3 && dir == 1'b0)) step();
        rld = 16'd2; cup = 16'd5;
        tag_ovr = "R8";
        step(); step(); step();
        chk("R8", int'(cnt), 6);
        chk("R8", int'(oref), 0);
        tag_ovr = "";
        repeat (20) step();

        // R11: phase shift of the descending edge
        mode = 2'b01; rld = 16'd8; cup = 16'd3; cdn = 16'd5;
        repeat (40) step();
        measure_rise(t_sym);
        mode = 2'b10;
        repeat (40) step();
        measure_rise(t_asym);
        chk("R11", t_sym - t_asym, 2);
        mode = 2'b01; cup = 16'd5; cdn = 16'd3;
        repeat (40) step();
        measure_rise(t_sym);
        mode = 2'b10;
        repeat (40) step();
        measure_rise(t_asym);
        chk("R11", t_asym - t_sym, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule